// File: doc/BRIEF.md
# SD Card Data Receive Controller

This block is the receive half of an SD/SDIO host data path. Once software raises the enable, it watches the sampled data line for a card start bit. It shifts the bits that follow into 32-bit words and pushes each finished word into an external FIFO through a one-cycle write strobe. Each block has a trailing CRC16, which the block compares with its own running value. It adds up the accepted bytes until the programmed transfer length is reached.

Between blocks the block waits for the next start bit under a programmable timeout. In SDIO mode it can also park after a block, and it stays parked until a stop request arrives. A timeout, a CRC mismatch, a FIFO overrun or a drop of the enable ends the transfer at once. Five sticky status flags record what happened. Each flag is cleared by writing a one to it, and a mask selects which flags drive the interrupt line. The line is sampled only in cycles where the bit-clock enable is high.

Top module: `sd_rx_ctrl`

## Requirements
- R1: After reset the block is idle with `fifo_wr`, `status` and `irq` low. It leaves idle only on a rising edge of `rx_enable`. If the enable is held high after a transfer has ended, no new start bit is accepted.
- R2: While waiting for a start bit, the counter is loaded with `tmo_limit`. If `tmo_limit`+1 consecutive sampled line values are high, status bit 0 (timeout) is set and the block goes idle. A low sample seen before then is taken as a start bit and opens a block.
- R3: Data bits are taken MSB-first into bytes. Four bytes fill one word, and the first byte of the word goes in bits 7:0. Each completed word is presented on `fifo_wdata` together with a single-cycle `fifo_wr` pulse.
- R4: If the block's byte count is not a multiple of four, the last word of the block is written with its unfilled upper bytes zero.
- R5: The block's data bits are followed by 16 CRC bits, MSB first, and then one end-bit slot. The CRC uses the polynomial x^16+x^12+x^5+1 (0x1021) and starts from zero. On a mismatch the block sets status bit 1 (CRC fail) and goes idle.
- R6: A block with a good CRC sets status bit 3 (block end). When the accepted bytes reach `xfer_bytes`, the block also sets status bit 4 (data end) and returns to idle.
- R7: If a word completes while `fifo_full` is high, no write is made. Status bit 2 (overrun) is set and the block goes idle.
- R8: After a good block that is not the last one, with both `sdio_en` and `rdwait_req` high, the block parks. While parked it ignores the line, and `rdwait_stop` sends it back to waiting for a start bit. If `sdio_en` is low, the block never parks.
- R9: `rx_enable` low forces the block idle on the next clock from any state. Bits that follow produce neither writes nor flags.
- R10: Status bits stay set until a one is written to the same bit of `status_clr`. If a flag is set and cleared in the same cycle, the set wins.
- R11: `irq` is high exactly when some status bit and its `irq_mask` bit are both high.
- R12: The line is sampled only in cycles where `bit_en` is high. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable: the line is sampled in this cycle |
| sd_line | input | 1 | Sampled card data line |
| rx_enable | input | 1 | Transfer enable; its rising edge starts a transfer |
| blk_bytes | input | 12 | Block size in bytes |
| xfer_bytes | input | 16 | Total transfer length in bytes |
| tmo_limit | input | 16 | Start-bit timeout in bit-enable cycles |
| rdwait_req | input | 1 | Request to park after the current block |
| rdwait_stop | input | 1 | Release from the parked state |
| sdio_en | input | 1 | SDIO mode, which permits parking |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| status | output | 5 | Sticky flags: 0 timeout, 1 CRC fail, 2 overrun, 3 block end, 4 data end |
| status_clr | input | 5 | Write-one-to-clear for `status` |
| irq_mask | input | 5 | Interrupt enable per status bit |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong state shows at the ports within one block at most. If the controller has left receive too early, words are missing from the FIFO. If it has stayed in receive too long, the next start bit is treated as data, so the CRC flag or the word contents break on the following end bit. A wrong bit counter or byte-lane index scrambles the very first word written. A faulty timeout counter changes the sample on which the timeout flag rises, and the bench probes one sample before and at that point. A parked state that leaks shows as extra FIFO writes while `rdwait_stop` is still low.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RECV  = 2'd2,
        ST_RWAIT = 2'd3
    } rx_state_e;

    localparam int NFLAG      = 5;
    localparam int FL_TMO     = 0;
    localparam int FL_CRC     = 1;
    localparam int FL_OVR     = 2;
    localparam int FL_BLK     = 3;
    localparam int FL_END     = 4;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int CRC_W      = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sd_rx_timer.sv
module sd_rx_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sd_rx_crc16.sv
module sd_rx_crc16
    import sd_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (shift) crc <= crc16_step(crc, bit_in);
    end
endmodule

// File: rtl/sd_rx_packer.sv
module sd_rx_packer
    import sd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    input  logic              last,
    output logic              word_rdy,
    output logic [WORD_W-1:0] word
);
    localparam int LANE_W = $clog2(WORD_BYTES);

    logic [7:0]        byte_sr;
    logic [2:0]        bit_idx;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] acc;
    logic [7:0]        byte_nxt;
    logic              byte_full;

    assign byte_nxt  = {byte_sr[6:0], bit_in};
    assign byte_full = shift && (bit_idx == 3'd7);
    assign word_rdy  = byte_full && ((lane == LANE_W'(WORD_BYTES - 1)) || last);

    always_comb begin
        word = acc;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (lane == LANE_W'(i)) word[8*i +: 8] = byte_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            byte_sr <= '0;
            bit_idx <= '0;
            lane    <= '0;
            acc     <= '0;
        end else if (shift) begin
            byte_sr <= byte_nxt;
            bit_idx <= bit_idx + 3'd1;
            if (byte_full) begin
                if (word_rdy) begin
                    acc  <= '0;
                    lane <= '0;
                end else begin
                    acc  <= word;
                    lane <= lane + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sd_rx_ctrl.sv
module sd_rx_ctrl
    import sd_rx_pkg::*;
#(
    parameter int BSZ_W  = 12,
    parameter int DLEN_W = 16,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              sd_line,
    input  logic              rx_enable,
    input  logic [BSZ_W-1:0]  blk_bytes,
    input  logic [DLEN_W-1:0] xfer_bytes,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              rdwait_req,
    input  logic              rdwait_stop,
    input  logic              sdio_en,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic [NFLAG-1:0]  status,
    input  logic [NFLAG-1:0]  status_clr,
    input  logic [NFLAG-1:0]  irq_mask,
    output logic              irq
);
    localparam int CNT_W = BSZ_W + 5;
    localparam int TOT_W = DLEN_W + 1;

    rx_state_e        state, nxt;
    logic [CNT_W-1:0] bit_cnt, data_bits;
    logic [TOT_W-1:0] tot_cnt, tot_next;
    logic [CRC_W-1:0] crc_rx, crc_calc;
    logic [NFLAG-1:0] set_fl;
    logic             en_q, step, in_data, in_crc, at_end, xfer_done;
    logic             pk_shift, pk_last, pk_rdy, enter_recv, enter_wait;
    logic             tmr_zero, tmr_dec, crc_ok;
    logic [WORD_W-1:0] pk_word;

    assign data_bits  = {2'b00, blk_bytes, 3'b000};
    assign in_data    = bit_cnt < data_bits;
    assign in_crc     = !in_data && (bit_cnt < data_bits + CNT_W'(CRC_W));
    assign at_end     = bit_cnt == data_bits + CNT_W'(CRC_W);
    assign tot_next   = tot_cnt + TOT_W'(blk_bytes);
    assign xfer_done  = tot_cnt >= TOT_W'(xfer_bytes);
    assign step       = bit_en && rx_enable && (state == ST_RECV);
    assign pk_shift   = step && in_data;
    assign pk_last    = bit_cnt == data_bits - CNT_W'(1);
    assign crc_ok     = crc_calc == crc_rx;
    assign enter_recv = (nxt == ST_RECV) && (state != ST_RECV);
    assign enter_wait = (nxt == ST_WAIT) && (state != ST_WAIT);
    assign tmr_dec    = bit_en && (state == ST_WAIT) && sd_line;

    sd_rx_timer #(.TMO_W(TMO_W)) i_timer (
        .clk(clk), .rst(rst), .load(enter_wait), .load_val(tmo_limit),
        .dec(tmr_dec), .expired(tmr_zero)
    );

    sd_rx_crc16 i_crc (
        .clk(clk), .rst(rst), .clr(enter_recv), .shift(pk_shift),
        .bit_in(sd_line), .crc(crc_calc)
    );

    sd_rx_packer i_pack (
        .clk(clk), .rst(rst), .clr(enter_recv), .shift(pk_shift),
        .bit_in(sd_line), .last(pk_last), .word_rdy(pk_rdy), .word(pk_word)
    );

    always_comb begin
        nxt    = state;
        set_fl = '0;
        unique case (state)
            ST_IDLE: if (rx_enable && !en_q) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!rx_enable || xfer_done) nxt = ST_IDLE;
                else if (bit_en) begin
                    if (!sd_line) nxt = ST_RECV;
                    else if (tmr_zero) begin
                        set_fl[FL_TMO] = 1'b1;
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_RECV: begin
                if (!rx_enable) nxt = ST_IDLE;
                else if (bit_en) begin
                    if (in_data && pk_rdy && fifo_full) begin
                        set_fl[FL_OVR] = 1'b1;
                        nxt = ST_IDLE;
                    end else if (at_end) begin
                        if (!crc_ok) begin
                            set_fl[FL_CRC] = 1'b1;
                            nxt = ST_IDLE;
                        end else begin
                            set_fl[FL_BLK] = 1'b1;
                            if (tot_next >= TOT_W'(xfer_bytes)) begin
                                set_fl[FL_END] = 1'b1;
                                nxt = ST_WAIT;
                            end else if (sdio_en && rdwait_req) nxt = ST_RWAIT;
                            else nxt = ST_WAIT;
                        end
                    end
                end
            end
            ST_RWAIT: begin
                if (!rx_enable) nxt = ST_IDLE;
                else if (rdwait_stop) nxt = ST_WAIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            en_q       <= 1'b0;
            bit_cnt    <= '0;
            tot_cnt    <= '0;
            crc_rx     <= '0;
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            state   <= nxt;
            en_q    <= rx_enable;
            fifo_wr <= pk_shift && pk_rdy && !fifo_full;
            if (pk_shift && pk_rdy && !fifo_full) fifo_wdata <= pk_word;
            if (state == ST_IDLE && nxt == ST_WAIT) tot_cnt <= '0;
            else if (set_fl[FL_BLK])                tot_cnt <= tot_next;
            if (enter_recv)  bit_cnt <= '0;
            else if (step)   bit_cnt <= bit_cnt + 1'b1;
            if (step && in_crc) crc_rx <= {crc_rx[CRC_W-2:0], sd_line};
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) status[g] <= 1'b0;
            else     status[g] <= (status[g] && !status_clr[g]) || set_fl[g];
        end
    end

    assign irq = |(status & irq_mask);
endmodule

// File: rtl/sd_rx_chk.sv
module sd_rx_chk
    import sd_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_enable,
    input logic             fifo_full,
    input logic             fifo_wr,
    input logic             sdio_en,
    input logic             rdwait_req,
    input logic [NFLAG-1:0] status,
    input logic [NFLAG-1:0] status_clr,
    input logic [NFLAG-1:0] irq_mask,
    input logic             irq,
    input rx_state_e        state
);
    a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !$past(fifo_full));

    a_r3_write_from_recv: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(state) == ST_RECV);

    a_r9_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> state == ST_IDLE);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ($past(status) & ~$past(status_clr)))
                  == ($past(status) & ~$past(status_clr))));

    a_r11_irq_masked_off: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !irq);

    a_r8_park_needs_sdio: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RWAIT && $past(state) == ST_RECV) |-> $past(sdio_en && rdwait_req));

    a_r2_timeout_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(status[FL_TMO]) |-> $past(state) == ST_WAIT);
endmodule

bind sd_rx_ctrl sd_rx_chk i_chk (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .sdio_en(sdio_en), .rdwait_req(rdwait_req),
    .status(status), .status_clr(status_clr), .irq_mask(irq_mask),
    .irq(irq), .state(state)
);

// File: tb/test_sd_rx_ctrl.sv
module test_sd_rx_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0, sd_line = 1'b1, rx_enable = 1'b0;
    logic [11:0] blk_bytes = '0;
    logic [15:0] xfer_bytes = '0, tmo_limit = '0;
    logic        rdwait_req = 1'b0, rdwait_stop = 1'b0, sdio_en = 1'b0, fifo_full = 1'b0;
    logic        fifo_wr, irq;
    logic [31:0] fifo_wdata;
    logic [4:0]  status, status_clr = '0, irq_mask = '0;

    int n_chk = 0, n_fail = 0, ncap = 0;
    bit done = 1'b0;
    logic [31:0] cap [32];

    always #4 clk = ~clk;

    sd_rx_ctrl i_sd_rx_ctrl (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sd_line(sd_line), .rx_enable(rx_enable),
        .blk_bytes(blk_bytes), .xfer_bytes(xfer_bytes), .tmo_limit(tmo_limit),
        .rdwait_req(rdwait_req), .rdwait_stop(rdwait_stop), .sdio_en(sdio_en),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .status(status), .status_clr(status_clr), .irq_mask(irq_mask), .irq(irq)
    );

    always @(negedge clk) if (fifo_wr && ncap < 32) begin
        cap[ncap] = fifo_wdata;
        ncap++;
    end

    // bsz[31:20] nblk[19:16] seed[15:8] bad_crc[7] fifo_full[6] exp_status[4:0]
    localparam logic [31:0] VEC [6] = '{
        {12'd8,  4'd1, 8'h11, 1'b0, 1'b0, 1'b0, 5'b11000},
        {12'd16, 4'd2, 8'h5A, 1'b0, 1'b0, 1'b0, 5'b11000},
        {12'd4,  4'd3, 8'hF0, 1'b0, 1'b0, 1'b0, 5'b11000},
        {12'd12, 4'd1, 8'h00, 1'b1, 1'b0, 1'b0, 5'b00010},
        {12'd8,  4'd1, 8'h33, 1'b0, 1'b1, 1'b0, 5'b00100},
        {12'd6,  4'd1, 8'h7E, 1'b0, 1'b0, 1'b0, 5'b11000}
    };

    function automatic logic [7:0] pat(input logic [7:0] s, input int k);
        return s + 8'(k * 37);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [7:0] s, input int n);
        logic [15:0] c = '0;
        logic fb;
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                fb = pat(s, k)[i] ^ c[15];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] s, input int n, input int j);
        logic [31:0] w = '0;
        for (int l = 0; l < 4; l++)
            if (4 * j + l < n) w[8*l +: 8] = pat(s, 4 * j + l);
        return w;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R12: the line carries the inverted value while bit_en is low
    task automatic drive_bit(input logic b);
        @(negedge clk);
        sd_line = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; sd_line = ~b;
    endtask

    task automatic send_block(input int n, input logic [7:0] s, input logic bad);
        logic [15:0] c;
        c = ref_crc(s, n);
        if (bad) c[0] = ~c[0];
        drive_bit(1'b0);
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) drive_bit(pat(s, k)[i]);
        for (int i = 15; i >= 0; i--) drive_bit(c[i]);
        drive_bit(1'b1);
        sd_line = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_xfer(input int bsz, input int len, input int tmo, input logic sdio, input logic rwr);
        @(negedge clk);
        rx_enable = 1'b0; status_clr = '1;
        @(negedge clk);
        status_clr = '0;
        blk_bytes = 12'(bsz); xfer_bytes = 16'(len); tmo_limit = 16'(tmo);
        sdio_en = sdio; rdwait_req = rwr; ncap = 0;
        rx_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({31'd0, fifo_wr}, 0, "R1 reset fifo_wr");
        chk({27'd0, status}, 0, "R1 reset status");
        chk({31'd0, irq}, 0, "R1 reset irq");

        for (int v = 0; v < 6; v++) begin
            int bsz, nblk, base;
            logic [7:0] seed;
            bsz = int'(VEC[v][31:20]); nblk = int'(VEC[v][19:16]); seed = VEC[v][15:8];
            start_xfer(bsz, bsz * nblk, 1000, 1'b0, 1'b0);
            fifo_full = VEC[v][6];
            base = 0;
            for (int b = 0; b < nblk; b++) send_block(bsz, seed + 8'(b), VEC[v][7]);
            fifo_full = 1'b0;
            chk({27'd0, status}, {27'd0, VEC[v][4:0]}, "R5 R6 R7 vector status");
            if (VEC[v][6]) chk(ncap, 0, "R7 no write on full");
            else begin
                chk(ncap, nblk * ((bsz + 3) / 4), "R3 word count");
                for (int b = 0; b < nblk; b++)
                    for (int j = 0; j < (bsz + 3) / 4; j++) begin
                        chk(cap[base], exp_word(seed + 8'(b), bsz, j), "R3 R4 R12 word data");
                        base++;
                    end
            end
        end

        // R1: enable still high after the transfer ended: no restart
        ncap = 0;
        send_block(8, 8'h44, 1'b0);
        chk(ncap, 0, "R1 no restart without enable edge");

        // R2: timeout after tmo_limit+1 high samples
        start_xfer(4, 4, 3, 1'b0, 1'b0);
        repeat (3) drive_bit(1'b1);
        chk({31'd0, status[0]}, 0, "R2 no timeout yet");
        drive_bit(1'b1);
        chk({27'd0, status}, 5'b00001, "R2 timeout flag");
        send_block(4, 8'h21, 1'b0);
        chk(ncap, 0, "R2 idle after timeout");

        // R2: start bit just before expiry
        start_xfer(4, 4, 3, 1'b0, 1'b0);
        repeat (3) drive_bit(1'b1);
        send_block(4, 8'h99, 1'b0);
        chk({27'd0, status}, 5'b11000, "R2 start before timeout");
        chk(cap[0], exp_word(8'h99, 4, 0), "R2 data after late start");

        // R8: park between blocks
        start_xfer(4, 8, 1000, 1'b1, 1'b1);
        send_block(4, 8'hA0, 1'b0);
        chk({27'd0, status}, 5'b01000, "R8 first block no data end");
        send_block(4, 8'hB0, 1'b0);
        chk(ncap, 1, "R8 line ignored while parked");
        @(negedge clk); rdwait_stop = 1'b1;
        @(negedge clk); rdwait_stop = 1'b0;
        send_block(4, 8'hC0, 1'b0);
        chk(ncap, 2, "R8 resumed after stop");
        chk(cap[1], exp_word(8'hC0, 4, 0), "R8 resumed word");
        chk({27'd0, status}, 5'b11000, "R8 data end");

        // R8: no park without SDIO mode
        start_xfer(4, 8, 1000, 1'b0, 1'b1);
        send_block(4, 8'h10, 1'b0);
        send_block(4, 8'h20, 1'b0);
        chk(ncap, 2, "R8 no park without sdio_en");

        // R9: disable mid-block
        start_xfer(8, 8, 1000, 1'b0, 1'b0);
        drive_bit(1'b0);
        for (int i = 0; i < 16; i++) drive_bit(1'b1);
        @(negedge clk); rx_enable = 1'b0;
        for (int i = 0; i < 64; i++) drive_bit(1'b0);
        repeat (2) @(negedge clk);
        chk(ncap, 0, "R9 no write after disable");
        chk({27'd0, status}, 0, "R9 no flag after disable");

        // R10: write-one-to-clear on one bit
        start_xfer(4, 4, 1000, 1'b0, 1'b0);
        send_block(4, 8'h55, 1'b0);
        @(negedge clk); status_clr = 5'b01000;
        @(negedge clk); status_clr = '0;
        chk({27'd0, status}, 5'b10000, "R10 clear only block end");

        // R11: interrupt masking
        irq_mask = 5'b00000; #1;
        chk({31'd0, irq}, 0, "R11 masked off");
        irq_mask = 5'b01111; #1;
        chk({31'd0, irq}, 0, "R11 non-matching mask");
        irq_mask = 5'b10000; #1;
        chk({31'd0, irq}, 1, "R11 matching mask");

        finish_run();
    end
endmodule